// File: doc/BRIEF.md
# Multi-batch shader and texture scheduler

This block steers batches of fragments between a small set of shader groups and a single texture pipe. Each shader group runs one batch on a program counter of its own, so several shader programs advance side by side. One batch at a time sits in the texture pipe. A batch enters through an admission handshake and waits in a first-in first-out ready queue until a shader group is free. It then fetches one instruction per cycle. When it meets a texture instruction it gives up its group and joins a second first-in first-out queue in front of the texture pipe. When the texture pipe reports completion, the batch rejoins the ready queue and later resumes at the instruction after the texture fetch. An end instruction retires the batch.

Instruction memory, fragment arithmetic and texture sampling lie outside the block. The instruction word comes back on a per-group opcode input in the same cycle as the fetch address. Admission stops while the number of batches in flight equals a parameter limit.

Top module: `frag_batch_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every fetch_valid, retire_valid and tex_valid output is low, both queues are empty, and admit_ready is high.
- R2: A batch is accepted in a cycle where admit_valid and admit_ready are both high. admit_ready is low exactly while the count of accepted batches not yet retired equals MAX_INFLIGHT. The count drops in the cycle that fetches an END, so admit_ready can rise in the next cycle.
- R3: Accepted and returning batches wait in a first-in first-out ready queue. A group that is free at the start of a cycle takes the next queue entry, and free groups are filled from the lowest index upward. A batch accepted in cycle n with a group free fetches first in cycle n+2, at its admitted start PC.
- R4: Opcode encoding on fetch_op is 2'b00 ALU, 2'b01 TEX, 2'b10 END, 2'b11 reserved (acts as ALU). On ALU or reserved, the same group fetches PC+1 in the next cycle.
- R5: On TEX, the group is free in the next cycle. The batch joins the texture queue with the saved PC (TEX address + 1). TEX fetches from several groups in one cycle join the queue in ascending group order.
- R6: tex_valid is high while a batch holds the texture pipe. tex_id and tex_pc stay steady until tex_done is sampled high. The next queued batch is issued in the following cycle. tex_done has no effect while tex_valid is low.
- R7: On tex_done, the batch rejoins the ready queue and later resumes at the saved PC. When a return and an acceptance fall in the same cycle, the returning batch is queued first.
- R8: On END in group g, retire_valid[g] is high for one cycle in the next cycle, with that batch's id, and the group is free.
- R9: All groups run concurrently with independent program counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| admit_valid | input | 1 | Batch offered for admission |
| admit_ready | output | 1 | Admission possible this cycle |
| admit_id | input | ID_W | Batch identifier |
| admit_pc | input | PC_W | Start program counter |
| fetch_valid | output | NUM_GROUPS | Group g is fetching this cycle |
| fetch_id | output | NUM_GROUPS x ID_W | Batch in each group |
| fetch_pc | output | NUM_GROUPS x PC_W | Fetch address per group |
| fetch_op | input | NUM_GROUPS x 2 | Opcode returned for each fetch address |
| tex_valid | output | 1 | Texture pipe holds a batch |
| tex_id | output | ID_W | Batch in the texture pipe |
| tex_pc | output | PC_W | Resume PC of that batch |
| tex_done | input | 1 | Texture work of the current batch is complete |
| retire_valid | output | NUM_GROUPS | Batch retired from group g |
| retire_id | output | NUM_GROUPS x ID_W | Identifier of the retired batch |

## Verification
Two collisions matter most. The first is a texture completion that rejoins the ready queue in the same cycle as a new acceptance. The second is several groups reaching a TEX fetch in the same cycle, so that they push into the texture queue together. Both are provoked by mixing start addresses that sit at or just before a TEX, and by running phases with short texture latency, long texture latency and tex_done held high. Queue order, resume addresses and retire order are judged each cycle against a queue-based model in the bench.

// File: rtl/frag_sched_pkg.sv
package frag_sched_pkg;
   typedef enum logic [1:0] {
      OP_ALU = 2'b00,
      OP_TEX = 2'b01,
      OP_END = 2'b10,
      OP_RSV = 2'b11
   } sched_op_e;
endpackage

// File: rtl/fsq_fifo.sv
module fsq_fifo #(
   parameter int W     = 10,
   parameter int DEPTH = 6,
   parameter int NPUSH = 2,
   parameter int NPOP  = 3,
   localparam int CW   = $clog2(DEPTH + 1),
   localparam int PW   = $clog2(NPOP + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NPUSH-1:0]            push_vld,
   input  logic [NPUSH-1:0][W-1:0]     push_dat,
   input  logic [PW-1:0]               pop_n,
   output logic [NPOP-1:0][W-1:0]      head,
   output logic [CW-1:0]               count
);
   logic [DEPTH-1:0][W-1:0] mem, mem_n;
   logic [CW-1:0]           cnt_n;

   always_comb begin
      int wp;
      mem_n = '0;
      for (int i = 0; i < DEPTH; i++)
         for (int j = 0; j < DEPTH; j++)
            if (j == i + int'(pop_n)) mem_n[i] = mem[j];
      wp = int'(count) - int'(pop_n);
      for (int k = 0; k < NPUSH; k++) begin
         if (push_vld[k]) begin
            for (int i = 0; i < DEPTH; i++)
               if (i == wp) mem_n[i] = push_dat[k];
            wp = wp + 1;
         end
      end
      cnt_n = CW'(wp);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem   <= '0;
         count <= '0;
      end else begin
         mem   <= mem_n;
         count <= cnt_n;
      end
   end

   for (genvar k = 0; k < NPOP; k++) begin : g_head
      if (k < DEPTH) begin : g_real
         assign head[k] = mem[k];
      end else begin : g_none
         assign head[k] = '0;
      end
   end
endmodule

// File: rtl/fsq_group.sv
module fsq_group
   import frag_sched_pkg::*;
#(
   parameter int ID_W = 4,
   parameter int PC_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [ID_W-1:0] load_id,
   input  logic [PC_W-1:0] load_pc,
   input  logic [1:0]      op,
   output logic            busy,
   output logic [ID_W-1:0] cur_id,
   output logic [PC_W-1:0] cur_pc,
   output logic [PC_W-1:0] next_pc,
   output logic            tex_req,
   output logic            end_req,
   output logic            ret_valid,
   output logic [ID_W-1:0] ret_id
);
   assign next_pc = cur_pc + PC_W'(1);
   assign tex_req = busy && (op == OP_TEX);
   assign end_req = busy && (op == OP_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         cur_id    <= '0;
         cur_pc    <= '0;
         ret_valid <= 1'b0;
         ret_id    <= '0;
      end else begin
         ret_valid <= end_req;
         if (end_req) ret_id <= cur_id;
         if (load) begin
            busy   <= 1'b1;
            cur_id <= load_id;
            cur_pc <= load_pc;
         end else if (tex_req || end_req) begin
            busy <= 1'b0;
         end else if (busy) begin
            cur_pc <= next_pc;
         end
      end
   end
endmodule

// File: rtl/frag_batch_sched.sv
module frag_batch_sched #(
   parameter int NUM_GROUPS   = 3,
   parameter int ID_W         = 4,
   parameter int PC_W         = 6,
   parameter int MAX_INFLIGHT = 6
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             admit_valid,
   output logic                             admit_ready,
   input  logic [ID_W-1:0]                  admit_id,
   input  logic [PC_W-1:0]                  admit_pc,
   output logic [NUM_GROUPS-1:0]            fetch_valid,
   output logic [NUM_GROUPS-1:0][ID_W-1:0]  fetch_id,
   output logic [NUM_GROUPS-1:0][PC_W-1:0]  fetch_pc,
   input  logic [NUM_GROUPS-1:0][1:0]       fetch_op,
   output logic                             tex_valid,
   output logic [ID_W-1:0]                  tex_id,
   output logic [PC_W-1:0]                  tex_pc,
   input  logic                             tex_done,
   output logic [NUM_GROUPS-1:0]            retire_valid,
   output logic [NUM_GROUPS-1:0][ID_W-1:0]  retire_id
);
   localparam int ENT_W = ID_W + PC_W;
   localparam int CNT_W = $clog2(MAX_INFLIGHT + 1);
   localparam int GP_W  = $clog2(NUM_GROUPS + 1);

   if (NUM_GROUPS < 1) begin : g_bad_groups
      $error("NUM_GROUPS must be at least 1");
   end
   if (MAX_INFLIGHT < 1) begin : g_bad_limit
      $error("MAX_INFLIGHT must be at least 1");
   end
   if (PC_W < 2 || ID_W < 1) begin : g_bad_width
      $error("PC_W must be at least 2 and ID_W at least 1");
   end

   logic [NUM_GROUPS-1:0]             busy, grant, tex_req, end_req;
   logic [NUM_GROUPS-1:0][PC_W-1:0]   nxt_pc;
   logic [NUM_GROUPS-1:0][ENT_W-1:0]  load_ent, tq_push_dat;
   logic [NUM_GROUPS-1:0][ENT_W-1:0]  rq_head;
   logic [1:0][ENT_W-1:0]             rq_push_dat;
   logic [1:0]                        rq_push_vld;
   logic [GP_W-1:0]                   rq_pop;
   logic [CNT_W-1:0]                  rq_cnt, tq_cnt;
   logic [0:0][ENT_W-1:0]             tq_head;
   logic                              tq_pop, tex_ret, admit_fire;
   logic [CNT_W-1:0]                  inflight, inflight_n;

   assign admit_ready = (inflight < CNT_W'(MAX_INFLIGHT));
   assign admit_fire  = admit_valid && admit_ready;
   assign tex_ret     = tex_valid && tex_done;

   // Ready queue: slot 0 carries the texture return, slot 1 the new batch
   assign rq_push_vld = {admit_fire, tex_ret};
   assign rq_push_dat = {{admit_id, admit_pc}, {tex_id, tex_pc}};

   always_comb begin
      int n;
      n        = 0;
      grant    = '0;
      load_ent = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (!busy[g] && n < int'(rq_cnt)) begin
            grant[g] = 1'b1;
            for (int k = 0; k < NUM_GROUPS; k++)
               if (k == n) load_ent[g] = rq_head[k];
            n = n + 1;
         end
      end
      rq_pop = GP_W'(n);
   end

   fsq_fifo #(.W(ENT_W), .DEPTH(MAX_INFLIGHT), .NPUSH(2), .NPOP(NUM_GROUPS)) i_ready_q (
      .clk(clk), .rst_n(rst_n), .push_vld(rq_push_vld), .push_dat(rq_push_dat),
      .pop_n(rq_pop), .head(rq_head), .count(rq_cnt));

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      fsq_group #(.ID_W(ID_W), .PC_W(PC_W)) i_grp (
         .clk(clk), .rst_n(rst_n), .load(grant[g]),
         .load_id(load_ent[g][ENT_W-1:PC_W]), .load_pc(load_ent[g][PC_W-1:0]),
         .op(fetch_op[g]), .busy(busy[g]), .cur_id(fetch_id[g]), .cur_pc(fetch_pc[g]),
         .next_pc(nxt_pc[g]), .tex_req(tex_req[g]), .end_req(end_req[g]),
         .ret_valid(retire_valid[g]), .ret_id(retire_id[g]));
      assign tq_push_dat[g] = {fetch_id[g], nxt_pc[g]};
   end
   assign fetch_valid = busy;

   assign tq_pop = !tex_valid && (tq_cnt != '0);

   fsq_fifo #(.W(ENT_W), .DEPTH(MAX_INFLIGHT), .NPUSH(NUM_GROUPS), .NPOP(1)) i_tex_q (
      .clk(clk), .rst_n(rst_n), .push_vld(tex_req), .push_dat(tq_push_dat),
      .pop_n(tq_pop), .head(tq_head), .count(tq_cnt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tex_valid <= 1'b0;
         tex_id    <= '0;
         tex_pc    <= '0;
      end else if (tex_ret) begin
         tex_valid <= 1'b0;
      end else if (tq_pop) begin
         tex_valid <= 1'b1;
         tex_id    <= tq_head[0][ENT_W-1:PC_W];
         tex_pc    <= tq_head[0][PC_W-1:0];
      end
   end

   always_comb begin
      int v;
      v = int'(inflight);
      if (admit_fire) v = v + 1;
      for (int g = 0; g < NUM_GROUPS; g++)
         if (end_req[g]) v = v - 1;
      inflight_n = CNT_W'(v);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inflight <= '0;
      else        inflight <= inflight_n;
   end
endmodule

// File: rtl/fsq_checker.sv
module fsq_checker #(
   parameter int NUM_GROUPS   = 3,
   parameter int ID_W         = 4,
   parameter int PC_W         = 6,
   parameter int MAX_INFLIGHT = 6
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             admit_valid,
   input logic                             admit_ready,
   input logic [NUM_GROUPS-1:0]            fetch_valid,
   input logic [NUM_GROUPS-1:0][ID_W-1:0]  fetch_id,
   input logic [NUM_GROUPS-1:0][PC_W-1:0]  fetch_pc,
   input logic [NUM_GROUPS-1:0][1:0]       fetch_op,
   input logic                             tex_valid,
   input logic [ID_W-1:0]                  tex_id,
   input logic [PC_W-1:0]                  tex_pc,
   input logic                             tex_done,
   input logic [NUM_GROUPS-1:0]            retire_valid,
   input logic [NUM_GROUPS-1:0][ID_W-1:0]  retire_id
);
   logic rst_d;
   int   chk_cnt;

   always_ff @(posedge clk) begin
      rst_d <= rst_n;
      if (rst_d === 1'b0) begin
         a_r1_reset_quiet: assert (fetch_valid == '0 && !tex_valid &&
                                   retire_valid == '0 && admit_ready);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chk_cnt <= 0;
      else chk_cnt <= chk_cnt + ((admit_valid && admit_ready) ? 1 : 0)
                      - $countones(retire_valid);
   end

   a_r2_limit: assert property (@(posedge clk) disable iff (!rst_n)
      chk_cnt <= MAX_INFLIGHT);

   a_r6_tex_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tex_valid && !tex_done) |=> (tex_valid && $stable(tex_id) && $stable(tex_pc)));

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      a_r4_alu_step: assert property (@(posedge clk) disable iff (!rst_n)
         (fetch_valid[g] && (fetch_op[g] == 2'b00 || fetch_op[g] == 2'b11))
         |=> (fetch_valid[g] && fetch_pc[g] == $past(fetch_pc[g]) + PC_W'(1)
              && fetch_id[g] == $past(fetch_id[g])));
      a_r5_tex_leave: assert property (@(posedge clk) disable iff (!rst_n)
         (fetch_valid[g] && fetch_op[g] == 2'b01) |=> !fetch_valid[g]);
      a_r8_end_retire: assert property (@(posedge clk) disable iff (!rst_n)
         (fetch_valid[g] && fetch_op[g] == 2'b10)
         |=> (retire_valid[g] && !fetch_valid[g] && retire_id[g] == $past(fetch_id[g])));
   end
endmodule

bind frag_batch_sched fsq_checker #(
   .NUM_GROUPS(NUM_GROUPS), .ID_W(ID_W), .PC_W(PC_W), .MAX_INFLIGHT(MAX_INFLIGHT)
) i_fsq_checker (.*);

// File: tb/test_frag_batch_sched.sv
`timescale 1ns/1ps
module test_frag_batch_sched;
   localparam int G = 3, IDW = 4, PCW = 6, MAXF = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic admit_valid = 1'b0, admit_ready;
   logic [IDW-1:0] admit_id = '0;
   logic [PCW-1:0] admit_pc = '0;
   logic [G-1:0] fetch_valid, retire_valid;
   logic [G-1:0][IDW-1:0] fetch_id, retire_id;
   logic [G-1:0][PCW-1:0] fetch_pc;
   logic [G-1:0][1:0] fetch_op;
   logic tex_valid, tex_done = 1'b0;
   logic [IDW-1:0] tex_id;
   logic [PCW-1:0] tex_pc;

   always #10 clk = ~clk;

   frag_batch_sched #(.NUM_GROUPS(G), .ID_W(IDW), .PC_W(PCW), .MAX_INFLIGHT(MAXF)) i_frag_batch_sched (
      .clk(clk), .rst_n(rst_n), .admit_valid(admit_valid), .admit_ready(admit_ready),
      .admit_id(admit_id), .admit_pc(admit_pc), .fetch_valid(fetch_valid),
      .fetch_id(fetch_id), .fetch_pc(fetch_pc), .fetch_op(fetch_op),
      .tex_valid(tex_valid), .tex_id(tex_id), .tex_pc(tex_pc), .tex_done(tex_done),
      .retire_valid(retire_valid), .retire_id(retire_id));

   int n_chk = 0, n_fail = 0, cyc = 0, tex_mode = 0, tcnt = 0, tissue = 0;
   int n_acc = 0, n_ret = 0, n_stall = 0;
   bit done_flag = 0;

   // Program image: every 8th word ends, positions 2 and 6 fetch texture, position 5 reserved
   function automatic logic [1:0] prog(int pc);
      if (pc % 8 == 7) return 2'b10;
      if (pc % 4 == 2) return 2'b01;
      if (pc % 8 == 5) return 2'b11;
      return 2'b00;
   endfunction

   always_comb
      for (int g = 0; g < G; g++) fetch_op[g] = prog(int'(fetch_pc[g]));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Reference model
   bit m_busy[G]; int m_id[G], m_pc[G]; bit m_rv[G]; int m_rid[G];
   int rq[$], tq[$];
   bit m_tb; int m_tid, m_tpc, m_inf;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int g = 0; g < G; g++) begin m_busy[g] = 0; m_rv[g] = 0; m_id[g] = 0; m_pc[g] = 0; m_rid[g] = 0; end
         rq.delete(); tq.delete(); m_tb = 0; m_tid = 0; m_tpc = 0; m_inf = 0;
      end else begin
         int rs, ts, inf0, dec;
         rs = rq.size(); ts = tq.size(); inf0 = m_inf; dec = 0;
         for (int g = 0; g < G; g++) begin
            m_rv[g] = 0;
            if (!m_busy[g]) begin
               if (rs > 0) begin
                  int e; e = rq.pop_front(); rs--;
                  m_busy[g] = 1; m_id[g] = e / 256; m_pc[g] = e % 256;
               end
            end else begin
               case (prog(m_pc[g]))
                  2'b01: begin tq.push_back(m_id[g] * 256 + (m_pc[g] + 1) % 64); m_busy[g] = 0; end
                  2'b10: begin m_rv[g] = 1; m_rid[g] = m_id[g]; m_busy[g] = 0; dec++; end
                  default: m_pc[g] = (m_pc[g] + 1) % 64;
               endcase
            end
         end
         if (m_tb) begin
            if (tex_done) begin rq.push_back(m_tid * 256 + m_tpc); m_tb = 0; end
         end else if (ts > 0) begin
            int e; e = tq.pop_front(); m_tb = 1; m_tid = e / 256; m_tpc = e % 256;
         end
         if (admit_valid && inf0 < MAXF) begin
            rq.push_back(int'(admit_id) * 256 + int'(admit_pc)); m_inf++; n_acc++;
         end
         m_inf = m_inf - dec;
      end
   end

   // Cycle-by-cycle comparison
   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         chk(admit_ready == (m_inf < MAXF), "R2 admit_ready", int'(admit_ready), int'(m_inf < MAXF));
         if (admit_valid && !admit_ready) n_stall++;
         for (int g = 0; g < G; g++) begin
            chk(fetch_valid[g] == m_busy[g], "R3 fetch_valid", int'(fetch_valid[g]), int'(m_busy[g]));
            if (m_busy[g]) begin
               chk(int'(fetch_id[g]) == m_id[g], "R9 fetch_id", int'(fetch_id[g]), m_id[g]);
               chk(int'(fetch_pc[g]) == m_pc[g], "R4 fetch_pc", int'(fetch_pc[g]), m_pc[g]);
            end
            chk(retire_valid[g] == m_rv[g], "R8 retire_valid", int'(retire_valid[g]), int'(m_rv[g]));
            if (m_rv[g]) chk(int'(retire_id[g]) == m_rid[g], "R8 retire_id", int'(retire_id[g]), m_rid[g]);
            if (retire_valid[g]) n_ret++;
         end
         chk(tex_valid == m_tb, "R6 tex_valid", int'(tex_valid), int'(m_tb));
         if (m_tb) begin
            chk(int'(tex_id) == m_tid, "R5 tex_id", int'(tex_id), m_tid);
            chk(int'(tex_pc) == m_tpc, "R7 tex_pc", int'(tex_pc), m_tpc);
         end
      end
   end

   // Texture responder: mode 0 latency cycles with issue, mode 1 done held high, mode 2 latency 4
   always @(negedge clk) begin
      if (!rst_n) begin tex_done <= 1'b0; tcnt = 0; end
      else if (tex_mode == 1) tex_done <= 1'b1;
      else if (tex_done) begin tex_done <= 1'b0; tcnt = 0; tissue++; end
      else if (tex_valid) begin
         if (tcnt >= ((tex_mode == 2) ? 4 : tissue % 3)) tex_done <= 1'b1;
         else tcnt++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 60000 && !done_flag) begin
         done_flag = 1;
         chk(0, "R2 watchdog cycles", cyc, 60000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic admit(input int id, input int pc);
      admit_valid = 1'b1; admit_id = IDW'(id); admit_pc = PCW'(pc);
      forever begin
         if (admit_ready) begin @(negedge clk); break; end
         @(negedge clk);
      end
      admit_valid = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (m_inf != 0 || m_tb || rq.size() != 0 || tq.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(fetch_valid == '0 && retire_valid == '0 && !tex_valid, "R1 reset outputs",
          int'(fetch_valid) + int'(retire_valid) + int'(tex_valid), 0);
      chk(admit_ready == 1'b1, "R1 reset admit_ready", int'(admit_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(fetch_valid == '0 && !tex_valid, "R1 first cycle idle", int'(fetch_valid), 0);
      // single batch: accepted at the next edge, fetches at start PC two cycles after acceptance
      admit(1, 0);
      chk(fetch_valid == '0, "R3 not yet loaded", int'(fetch_valid), 0);
      @(negedge clk);
      chk(fetch_valid == 3'b001 && fetch_pc[0] == '0, "R3 first fetch group0",
          int'(fetch_valid), 1);
      wait_idle();
      // mixed start addresses, back-to-back admission reaching the limit
      for (int i = 0; i < 12; i++) admit(2 + i, (i * 5) % 48);
      wait_idle();
      chk(n_stall > 0, "R2 limit stalled admission", n_stall, 1);
      // texture done held high, starts at texture positions
      tex_mode = 1;
      for (int i = 0; i < 6; i++) admit(1 + i, 2 + 8 * i);
      wait_idle();
      // long texture latency
      tex_mode = 2;
      for (int i = 0; i < 9; i++) admit(7 + i, (i * 3) % 40);
      wait_idle();
      tex_mode = 0;
      for (int i = 0; i < 8; i++) admit(i, (i * 7) % 50);
      wait_idle();
      chk(n_ret == n_acc, "R8 every batch retired once", n_ret, n_acc);
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule